// File: doc/BRIEF.md
# GPIO Line Interrupt Condition Detector

This block watches every line of a general-purpose I/O bank and records, per line, whether the event that software armed on that line has occurred. Each pin first passes through a synchronizer. It is then compared with its value one cycle earlier to find edges, or taken as it is to find a level. When the armed condition is seen, the line's sticky status bit is set.

Three independent configuration bits choose the trigger type of each line: a level-select bit, a polarity bit and a both-edges bit. No single mode field exists. Software clears a status bit by pulsing a one on the matching clear input. The interrupt output of each line is its status bit ANDed with its mask bit. As a result, an event can be recorded while the line is masked and raised later, as soon as the line is unmasked. Bus decoding, pad control and merging the interrupts of several banks belong to the surrounding logic.

Top module: `gpio_evt_top`

## Requirements
- R1: A pin change reaches the status bit on the third rising clock edge after it is applied: two synchronizer stages, then the status register. It is not visible after only two edges. Reset must hold the pins low.
- R2: When the level bit is 0 and the both-edges bit is 0, a polarity bit of 1 arms the line for rising edges and 0 arms it for falling edges. The opposite edge does not set status.
- R3: When the level bit is 0 and the both-edges bit is 1, a rising edge sets status and a falling edge sets status. The polarity bit has no effect in this mode.
- R4: A level bit of 1 makes the line level-sensitive, whatever the both-edges bit is. A polarity bit of 1 selects high as the active level and 0 selects low.
- R5: In level mode the status bit is set again on every cycle the synchronized pin is at the active level. A clear pulse therefore has no lasting effect until the pin has left that level.
- R6: A 1 on a line's clear input for one cycle clears that line's status bit at the next edge. A 0 leaves the bit as it is. Without a set or a clear, a status bit holds its value.
- R7: If a set condition and a clear pulse meet on a line in the same cycle, the status bit ends up set.
- R8: Each line's interrupt output equals its status bit ANDed with its mask bit, with no register in between. Setting the mask of a line whose status is already 1 raises its interrupt in the same cycle.
- R9: Changing any configuration bit while the pin is steady does not set status in edge modes. The previous-value register follows the synchronized pin in every mode.
- R10: After reset, every status bit and every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | WIDTH | Asynchronous pin levels |
| cfgLevel | input | WIDTH | 1 = level-sensitive line |
| cfgPolarity | input | WIDTH | Active-high or rising when 1, active-low or falling when 0 |
| cfgBoth | input | WIDTH | 1 = both edges (edge mode only) |
| maskEn | input | WIDTH | Per-line interrupt enable |
| clrPulse | input | WIDTH | Write-one-to-clear strobe for status |
| statusOut | output | WIDTH | Sticky status bits |
| irqOut | output | WIDTH | Status gated by mask |

## Verification
Two functions can act on one line in the same cycle: recording a new event and the software clear. To make them meet, the bench raises the clear strobe during the cycle just before the third edge after a pin rise, which is the edge at which the rising edge is recorded. It judges the result by checking that status reads 1 afterwards. A second pairing comes from level mode: the bench pulses a clear while the pin is still active and expects the bit to stay set, then pulses again once the pin is inactive and expects 0.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE_ONE  = 2'd0,
    MODE_EDGE_BOTH = 2'd1,
    MODE_LEVEL     = 2'd2
  } trigMode_e;

  // strobes from control to datapath, one pair per line
  typedef struct packed {
    logic setEv;
    logic clrEv;
  } lineStrobe_t;

  // level bit takes priority over the both-edges bit
  function automatic trigMode_e decodeMode(input logic lvl, input logic both);
    if (lvl)       return MODE_LEVEL;
    else if (both) return MODE_EDGE_BOTH;
    else           return MODE_EDGE_ONE;
  endfunction

endpackage

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WIDTH-1:0]              pinIn,
  input  lineStrobe_t [WIDTH-1:0]       strobes,
  output logic [WIDTH-1:0]              syncVal,
  output logic [WIDTH-1:0]              prevVal,
  output logic [WIDTH-1:0]              statusQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] syncChain [SYNC_STAGES];
  logic [WIDTH-1:0] setVec, clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncVal = syncChain[LAST];

  // previous value follows the pin whatever the mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    assign setVec[i] = strobes[i].setEv;
    assign clrVec[i] = strobes[i].clrEv;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             statusQ[i] <= 1'b0;
      else if (setVec[i])    statusQ[i] <= 1'b1;   // set beats clear
      else if (clrVec[i])    statusQ[i] <= 1'b0;
    end
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((statusQ & $past(setVec)) == $past(setVec)));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~setVec) != '0) |=> ((statusQ & $past(clrVec & ~setVec)) == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statusQ ^ $past(statusQ)) & ~$past(setVec | clrVec)) == '0));

  a_r9_prev_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevVal == $past(syncVal)));

endmodule

// File: rtl/gpio_evt_control.sv
module gpio_evt_control
  import gpio_evt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WIDTH-1:0]        syncVal,
  input  logic [WIDTH-1:0]        prevVal,
  input  logic [WIDTH-1:0]        cfgLevel,
  input  logic [WIDTH-1:0]        cfgPolarity,
  input  logic [WIDTH-1:0]        cfgBoth,
  input  logic [WIDTH-1:0]        clrPulse,
  output lineStrobe_t [WIDTH-1:0] strobes
);
  logic [WIDTH-1:0] setVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_qual
    logic      rise, fall, active;
    trigMode_e mode;
    always_comb begin
      rise   = syncVal[i] & ~prevVal[i];
      fall   = ~syncVal[i] & prevVal[i];
      active = ~(syncVal[i] ^ cfgPolarity[i]);
      mode   = decodeMode(cfgLevel[i], cfgBoth[i]);
      unique case (mode)
        MODE_LEVEL:     setVec[i] = active;
        MODE_EDGE_BOTH: setVec[i] = rise | fall;
        default:        setVec[i] = cfgPolarity[i] ? rise : fall;
      endcase
      strobes[i].setEv = setVec[i];
      strobes[i].clrEv = clrPulse[i];
    end
  end

  a_r9_quiet_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (setVec & ~cfgLevel & ~(syncVal ^ prevVal)) == '0);

  a_r4_level_inactive: assert property (@(posedge clk) disable iff (!rstN)
    (setVec & cfgLevel & (syncVal ^ cfgPolarity)) == '0);

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] cfgLevel,
  input  logic [WIDTH-1:0] cfgPolarity,
  input  logic [WIDTH-1:0] cfgBoth,
  input  logic [WIDTH-1:0] maskEn,
  input  logic [WIDTH-1:0] clrPulse,
  output logic [WIDTH-1:0] statusOut,
  output logic [WIDTH-1:0] irqOut
);
  lineStrobe_t [WIDTH-1:0] strobes;
  logic [WIDTH-1:0] syncVal, prevVal;

  gpio_evt_control #(.WIDTH(WIDTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .syncVal(syncVal), .prevVal(prevVal),
    .cfgLevel(cfgLevel), .cfgPolarity(cfgPolarity), .cfgBoth(cfgBoth),
    .clrPulse(clrPulse), .strobes(strobes)
  );

  gpio_evt_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobes(strobes),
    .syncVal(syncVal), .prevVal(prevVal), .statusQ(statusOut)
  );

  // mask gates only the output, never the recorded status
  assign irqOut = statusOut & maskEn;

endmodule

// File: tb/test_gpio_evt_top.sv
`timescale 1ns/1ps
module test_gpio_evt_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] pinIn = '0, cfgLevel = '0, cfgPolarity = '0, cfgBoth = '0;
  logic [W-1:0] maskEn = '0, clrPulse = '0;
  logic [W-1:0] statusOut, irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_evt_top #(.WIDTH(W)) i_gpio_evt_top (.*);

  // {lvl, pol, both, from, to, expected status}
  localparam logic [5:0] VECS [0:11] = '{
    6'b010011, 6'b010100, 6'b000101, 6'b000010,
    6'b001011, 6'b011101, 6'b110011, 6'b110000,
    6'b100110, 6'b100101, 6'b101110, 6'b111101
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clearLines(input logic [W-1:0] m);
    clrPulse = m; cyc(1); clrPulse = '0;
  endtask

  initial begin
    cyc(3);
    chk("R10 status after reset", statusOut, '0);
    chk("R10 irq after reset", irqOut, '0);
    rstN = 1'b1;
    cyc(2);

    // table walk on line 0
    maskEn = 8'h01;
    for (int k = 0; k < 12; k++) begin
      cfgLevel[0] = VECS[k][5]; cfgPolarity[0] = VECS[k][4]; cfgBoth[0] = VECS[k][3];
      pinIn[0] = VECS[k][2];
      cyc(5);
      clearLines(8'h01);
      pinIn[0] = VECS[k][1];
      cyc(5);
      // R2 edge one, R3 both edges, R4/R5 level
      chk($sformatf("R2/R3/R4 vector %0d status", k), {7'b0, statusOut[0]}, {7'b0, VECS[k][0]});
      chk($sformatf("R8 vector %0d irq", k), {7'b0, irqOut[0]}, {7'b0, VECS[k][0]});
    end

    // R1 latency: rising edge on line 2
    cfgLevel = '0; cfgBoth = '0; cfgPolarity = 8'h04; pinIn = '0;
    cyc(4); clearLines('1);
    pinIn[2] = 1'b1;
    cyc(2);
    chk("R1 not yet after two edges", statusOut & 8'h04, 8'h00);
    cyc(1);
    chk("R1 set on third edge", statusOut & 8'h04, 8'h04);

    // R8 masked pending then unmask
    maskEn = '0;
    chk("R8 masked irq low", irqOut, '0);
    maskEn = 8'h04; #1;
    chk("R8 unmask raises irq at once", irqOut, 8'h04);

    // R6 writing zero leaves bit, one clears it
    clearLines(8'hFB);
    chk("R6 zero write no effect", statusOut & 8'h04, 8'h04);
    clearLines(8'h04);
    chk("R6 one clears", statusOut & 8'h04, 8'h00);

    // R7 set and clear in the same cycle on line 3
    cfgPolarity[3] = 1'b1;
    pinIn[3] = 1'b1;
    cyc(2);
    clrPulse = 8'h08; cyc(1); clrPulse = '0;
    chk("R7 set beats clear", statusOut & 8'h08, 8'h08);
    clearLines(8'h08);

    // R5 level clear ineffective while active (line 4, active high)
    cfgLevel[4] = 1'b1; cfgPolarity[4] = 1'b1; pinIn[4] = 1'b1;
    cyc(4);
    clearLines(8'h10);
    chk("R5 clear while active keeps bit", statusOut & 8'h10, 8'h10);
    pinIn[4] = 1'b0;
    cyc(3);
    chk("R5 sticky after pin leaves", statusOut & 8'h10, 8'h10);
    clearLines(8'h10);
    chk("R5 clear after inactive", statusOut & 8'h10, 8'h00);

    // R9 configuration churn with steady pin on line 5
    cfgLevel[5] = 1'b0; cfgBoth[5] = 1'b0; cfgPolarity[5] = 1'b0; pinIn[5] = 1'b1;
    cyc(5); clearLines(8'h20);
    cfgPolarity[5] = 1'b1; cyc(2);
    cfgBoth[5] = 1'b1; cyc(2);
    cfgPolarity[5] = 1'b0; cfgBoth[5] = 1'b0; cyc(3);
    chk("R9 config change no event", statusOut & 8'h20, 8'h00);
    pinIn[5] = 1'b0; cyc(3);
    chk("R9 falling still detected", statusOut & 8'h20, 8'h20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule